// File: doc/BRIEF.md
# I2C auto-mode transaction sequencer

This block carries out one complete I2C master message without per-byte help from a processor. Software presets the target address, the byte count, the direction and whether the message should end with a stop. A one-cycle `run` pulse then launches the whole message. The sequencer issues a start condition and one or two address bytes, and with 10-bit addressing in a read it also issues a repeated start. It then moves data bytes from a TX FIFO onto the bus, or from the bus into an RX FIFO. Finally it either issues a stop or parks in a hold state so that the next message begins with a repeated start. Bit timing lives in a separate bit engine. The sequencer hands it one command at a time (start, write byte, read byte, stop) and waits for the engine's completion pulse, which also returns the acknowledge bit and any received byte.

The state machine has these states: `S_IDLE`, `S_START`, `S_ADDR1`, `S_ADDR2`, `S_RSTART`, `S_ADDR3`, `S_TX`, `S_RX`, `S_STOP` and `S_HOLD`. Its transitions are:
- launch: `S_IDLE` or `S_HOLD` to `S_START` on `run`.
- start-done: `S_START` to `S_ADDR1`.
- ten-bit: `S_ADDR1` to `S_ADDR2`.
- seven-bit-go: `S_ADDR1` to `S_TX` or `S_RX`.
- ten-bit-write: `S_ADDR2` to `S_TX`.
- ten-bit-read: `S_ADDR2` to `S_RSTART`, then `S_RSTART` to `S_ADDR3`, then `S_ADDR3` to `S_RX`.
- addr-nack: any address state to `S_STOP`, setting no-device.
- data-nack: `S_TX` to `S_STOP`, setting no-ACK.
- starve: `S_TX` to `S_STOP` when the TX FIFO stays empty past the limit, setting abort.
- last-stop: `S_TX` or `S_RX` to `S_STOP` after the final byte.
- last-hold: `S_TX` or `S_RX` to `S_HOLD` after the final byte.
- stop-done: `S_STOP` to `S_IDLE`.
- soft-reset: any state to `S_IDLE` while `sw_reset` is high.

An interrupt unit watches both FIFO levels and the end of each message. It keeps four write-one-to-clear status bits, and these are masked onto a single interrupt line.

Top module: `i2c_auto_seq`

## Requirements
- R1: A `run` pulse in idle or hold captures `cfg_len`, `cfg_read`, `cfg_stop`, `cfg_addr` and `cfg_addr10`, raises `st_mbusy` on the next cycle, and issues a start command first (`be_cmd` encodings: 0 start, 1 write byte, 2 read byte, 3 stop).
- R2: In 7-bit mode the single address byte is `{cfg_addr[6:0], read}`. In 10-bit mode a write sends `{5'b11110, cfg_addr[9:8], 0}` followed by `cfg_addr[7:0]`. A 10-bit read sends those same two bytes, then a repeated start, then `{5'b11110, cfg_addr[9:8], 1}`.
- R3: A write sends the TX FIFO bytes in push order. A NACK on a data byte sets `st_noack` and is followed by a stop.
- R4: A read issues read commands with `be_ack_out` = 1 (ACK) for every byte except the last, which gets 0 (NACK). Each received byte is placed in the RX FIFO in order.
- R5: With `cfg_stop` = 1 the message ends with a stop, and afterwards all status outputs read 0. With `cfg_stop` = 0 no stop is issued: `st_done` and `st_mbusy` stay 1, and the next `run` begins with a start (a repeated start on the bus).
- R6: A NACK on any address byte sets `st_nodev`, is followed by a stop, and sends no data. At most one of abort, no-ACK and no-device is ever set.
- R7: A byte count of 0 is executed as a one-byte transfer.
- R8: If the TX FIFO stays empty in the write data phase for more than `STALL_LIMIT` cycles, `st_abort` is set and a stop is issued.
- R9: `irq_stat` bit 0 is TX almost-empty (writing and TX count ≤ `tx_lvl`). Bit 1 is RX almost-full (`rx_lvl` ≠ 0 and RX count ≥ `rx_lvl`). Bit 2 is trailing. Bit 3 is completion, set at the end of every message. A 1 on `irq_clr` clears the bit, and `irq` is the OR of the bits enabled in `irq_en`.
- R10: The trailing bit is set when the RX FIFO holds between 1 and `rx_lvl`−1 bytes and has seen no push or pop for `trail_len` cycles. It is never set while the count is at or above `rx_lvl`.
- R11: While `sw_reset` is high the sequencer returns to idle, both FIFOs empty, and the status and interrupt bits clear. Bytes pushed before the reset are never sent.
- R12: `be_valid` is asserted only while busy. Once asserted, the command and write data stay stable until `be_done`, and each `be_done` completes exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous soft reset, held high to reset |
| run | input | 1 | Launch pulse |
| cfg_len | input | LEN_W | Byte count (0 treated as 1) |
| cfg_read | input | 1 | 1 = read, 0 = write |
| cfg_stop | input | 1 | 1 = issue stop at end |
| cfg_addr | input | 10 | Target address |
| cfg_addr10 | input | 1 | 10-bit addressing |
| tx_lvl | input | CW | TX almost-empty level |
| rx_lvl | input | CW | RX almost-full level |
| trail_len | input | 4 | Trailing idle cycles |
| tx_push | input | 1 | Push into TX FIFO |
| tx_data | input | 8 | TX FIFO write data |
| tx_full | output | 1 | TX FIFO full |
| rx_pop | input | 1 | Pop from RX FIFO |
| rx_data | output | 8 | RX FIFO head |
| rx_empty | output | 1 | RX FIFO empty |
| irq_en | input | 4 | Interrupt enables |
| irq_clr | input | 4 | Write-one-to-clear strobes |
| irq_stat | output | 4 | Interrupt status |
| irq | output | 1 | Interrupt line |
| st_done | output | 1 | Ended without stop |
| st_abort | output | 1 | TX starvation timeout |
| st_noack | output | 1 | Data byte NACKed |
| st_nodev | output | 1 | Address NACKed |
| st_mbusy | output | 1 | Master busy (owns the bus) |
| be_valid | output | 1 | Command to bit engine valid |
| be_cmd | output | 2 | Bit engine command |
| be_wdata | output | 8 | Byte to transmit (0 otherwise) |
| be_ack_out | output | 1 | ACK to drive after a read byte |
| be_done | input | 1 | Bit engine command complete |
| be_ack_in | input | 1 | 1 = slave acknowledged |
| be_rdata | input | 8 | Byte received by bit engine |

## Verification
The assertions assume the bit engine pulses `be_done` for one cycle, only while a command is outstanding. They also assume `run` arrives only in idle or hold, and that `cfg_*` stay stable around the launch edge. The bench models the bit engine to honour exactly this: it accepts a command only when it is idle, answers after a fixed latency and drops its outstanding command on soft reset. The bench changes configuration only on the cycle of `run`. Every command the sequencer issues is compared against a queue of expected commands that the bench derives from the configuration and its own ACK policy.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR1, S_ADDR2, S_RSTART,
        S_ADDR3, S_TX, S_RX, S_STOP, S_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_WRITE = 2'd1,
        BC_READ  = 2'd2,
        BC_STOP  = 2'd3
    } bus_cmd_t;

    localparam int IRQ_TXAE  = 0;
    localparam int IRQ_RXAF  = 1;
    localparam int IRQ_TRAIL = 2;
    localparam int IRQ_CMPL  = 3;
    localparam int IRQ_N     = 4;

    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/i2cseq_irq.sv
module i2cseq_irq
    import i2cseq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CW-1:0]    tx_cnt,
    input  logic [CW-1:0]    rx_cnt,
    input  logic [CW-1:0]    tx_lvl,
    input  logic [CW-1:0]    rx_lvl,
    input  logic             tx_phase,
    input  logic [3:0]       trail_len,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             xfer_end,
    input  logic [IRQ_N-1:0] irq_clr,
    input  logic [IRQ_N-1:0] irq_en,
    output logic [IRQ_N-1:0] irq_stat,
    output logic             irq
);
    logic [IRQ_N-1:0] stat_q, set_v;
    logic [3:0]       idle_q;
    logic             trail_cond;

    // rx holds some bytes but fewer than the almost-full level
    assign trail_cond = (rx_cnt != '0) && (rx_cnt < rx_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           idle_q <= '0;
        else if (clr || rx_push || rx_pop || !trail_cond) idle_q <= '0;
        else if (idle_q != trail_len)         idle_q <= idle_q + 1'b1;
    end

    always_comb begin
        set_v            = '0;
        set_v[IRQ_TXAE]  = tx_phase && (tx_cnt <= tx_lvl);
        set_v[IRQ_RXAF]  = (rx_lvl != '0) && (rx_cnt >= rx_lvl);
        set_v[IRQ_TRAIL] = trail_cond && !rx_push && !rx_pop && (idle_q == trail_len);
        set_v[IRQ_CMPL]  = xfer_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stat_q <= '0;
        else if (clr) stat_q <= '0;
        else          stat_q <= (stat_q & ~irq_clr) | set_v;
    end

    assign irq_stat = stat_q;
    assign irq      = |(stat_q & irq_en);
endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
    import i2cseq_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int STALL_LIMIT = 1000,
    parameter int STALL_W     = $clog2(STALL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             run,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_read,
    input  logic             cfg_stop,
    input  logic [9:0]       cfg_addr,
    input  logic             cfg_addr10,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    input  logic             rx_full,
    input  logic             be_done,
    input  logic             be_ack_in,
    output logic             be_valid,
    output logic [1:0]       be_cmd,
    output logic [7:0]       be_wdata,
    output logic             be_ack_out,
    output logic             tx_pop,
    output logic             rx_push,
    output logic             xfer_end,
    output logic             tx_phase,
    output logic             st_done,
    output logic             st_abort,
    output logic             st_noack,
    output logic             st_nodev,
    output logic             st_mbusy
);
    seq_state_t       state, nxt;
    logic [LEN_W-1:0] remain_q;
    logic [9:0]       addr_q;
    logic             rd_q, stop_q, a10_q;
    logic [STALL_W-1:0] stall_q;
    logic             done_q, abort_q, noack_q, nodev_q;
    logic             launch, nodev_set, noack_set, abort_set, last;
    bus_cmd_t         cmd_v;

    assign last = (remain_q == LEN_W'(1));

    // next-state decision
    always_comb begin
        nxt       = state;
        launch    = 1'b0;
        nodev_set = 1'b0;
        noack_set = 1'b0;
        abort_set = 1'b0;
        unique case (state)
            S_IDLE, S_HOLD: if (run) begin
                nxt    = S_START;
                launch = 1'b1;
            end
            S_START: if (be_done) nxt = S_ADDR1;
            S_ADDR1: if (be_done) begin
                if (!be_ack_in) begin
                    nxt = S_STOP; nodev_set = 1'b1;
                end else if (a10_q) nxt = S_ADDR2;
                else                nxt = rd_q ? S_RX : S_TX;
            end
            S_ADDR2: if (be_done) begin
                if (!be_ack_in) begin
                    nxt = S_STOP; nodev_set = 1'b1;
                end else nxt = rd_q ? S_RSTART : S_TX;
            end
            S_RSTART: if (be_done) nxt = S_ADDR3;
            S_ADDR3: if (be_done) begin
                if (!be_ack_in) begin
                    nxt = S_STOP; nodev_set = 1'b1;
                end else nxt = S_RX;
            end
            S_TX: begin
                if (be_done) begin
                    if (!be_ack_in) begin
                        nxt = S_STOP; noack_set = 1'b1;
                    end else if (last) nxt = stop_q ? S_STOP : S_HOLD;
                end else if (tx_empty && stall_q == STALL_W'(STALL_LIMIT)) begin
                    nxt = S_STOP; abort_set = 1'b1;
                end
            end
            S_RX: if (be_done && last) nxt = stop_q ? S_STOP : S_HOLD;
            S_STOP: if (be_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (sw_reset) begin
            nxt       = S_IDLE;
            launch    = 1'b0;
            nodev_set = 1'b0;
            noack_set = 1'b0;
            abort_set = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // message context, stall timer and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0; addr_q <= '0; rd_q <= 1'b0; stop_q <= 1'b0; a10_q <= 1'b0;
            stall_q  <= '0;
            done_q   <= 1'b0; abort_q <= 1'b0; noack_q <= 1'b0; nodev_q <= 1'b0;
        end else if (sw_reset) begin
            stall_q  <= '0;
            done_q   <= 1'b0; abort_q <= 1'b0; noack_q <= 1'b0; nodev_q <= 1'b0;
        end else begin
            if (launch) begin
                remain_q <= (cfg_len == '0) ? LEN_W'(1) : cfg_len;
                addr_q   <= cfg_addr;
                rd_q     <= cfg_read;
                stop_q   <= cfg_stop;
                a10_q    <= cfg_addr10;
                done_q   <= 1'b0; abort_q <= 1'b0; noack_q <= 1'b0; nodev_q <= 1'b0;
            end
            if ((state == S_TX || state == S_RX) && be_done) remain_q <= remain_q - 1'b1;
            stall_q <= (state == S_TX && tx_empty && !be_done) ? stall_q + 1'b1 : '0;
            if (nodev_set) nodev_q <= 1'b1;
            if (noack_set) noack_q <= 1'b1;
            if (abort_set) abort_q <= 1'b1;
            if (nxt == S_HOLD && state != S_HOLD) done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        be_valid   = 1'b0;
        cmd_v      = BC_WRITE;
        be_wdata   = 8'h00;
        be_ack_out = 1'b0;
        unique case (state)
            S_START, S_RSTART: begin be_valid = 1'b1; cmd_v = BC_START; end
            S_STOP:  begin be_valid = 1'b1; cmd_v = BC_STOP; end
            S_ADDR1: begin
                be_valid = 1'b1;
                be_wdata = a10_q ? {TEN_BIT_TAG, addr_q[9:8], 1'b0} : {addr_q[6:0], rd_q};
            end
            S_ADDR2: begin be_valid = 1'b1; be_wdata = addr_q[7:0]; end
            S_ADDR3: begin be_valid = 1'b1; be_wdata = {TEN_BIT_TAG, addr_q[9:8], 1'b1}; end
            S_TX:    begin be_valid = !tx_empty; be_wdata = tx_head; end
            S_RX:    begin be_valid = !rx_full; cmd_v = BC_READ; be_ack_out = !last; end
            default: ;
        endcase
    end

    assign be_cmd   = cmd_v;
    assign tx_pop   = (state == S_TX) && be_done;
    assign rx_push  = (state == S_RX) && be_done;
    assign tx_phase = (state == S_TX);
    assign xfer_end = !sw_reset && (((state == S_STOP) && be_done) ||
                                    ((nxt == S_HOLD) && (state != S_HOLD)));
    assign st_done  = done_q;
    assign st_abort = abort_q;
    assign st_noack = noack_q;
    assign st_nodev = nodev_q;
    assign st_mbusy = (state != S_IDLE);
endmodule

// File: rtl/i2c_auto_seq.sv
module i2c_auto_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int STALL_LIMIT = 1000,
    parameter int CW          = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             run,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_read,
    input  logic             cfg_stop,
    input  logic [9:0]       cfg_addr,
    input  logic             cfg_addr10,
    input  logic [CW-1:0]    tx_lvl,
    input  logic [CW-1:0]    rx_lvl,
    input  logic [3:0]       trail_len,
    input  logic             tx_push,
    input  logic [7:0]       tx_data,
    output logic             tx_full,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic             rx_empty,
    input  logic [3:0]       irq_en,
    input  logic [3:0]       irq_clr,
    output logic [3:0]       irq_stat,
    output logic             irq,
    output logic             st_done,
    output logic             st_abort,
    output logic             st_noack,
    output logic             st_nodev,
    output logic             st_mbusy,
    output logic             be_valid,
    output logic [1:0]       be_cmd,
    output logic [7:0]       be_wdata,
    output logic             be_ack_out,
    input  logic             be_done,
    input  logic             be_ack_in,
    input  logic [7:0]       be_rdata
);
    localparam int STALL_W = $clog2(STALL_LIMIT + 1);

    logic          tx_empty, rx_full, tx_pop, rx_push, xfer_end, tx_phase;
    logic [7:0]    tx_head;
    logic [CW-1:0] tx_cnt, rx_cnt;

    i2cseq_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CW)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(sw_reset),
        .push(tx_push), .din(tx_data), .pop(tx_pop), .dout(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    i2cseq_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CW(CW)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(sw_reset),
        .push(rx_push), .din(be_rdata), .pop(rx_pop), .dout(rx_data),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    i2cseq_fsm #(.LEN_W(LEN_W), .STALL_LIMIT(STALL_LIMIT), .STALL_W(STALL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .run(run),
        .cfg_len(cfg_len), .cfg_read(cfg_read), .cfg_stop(cfg_stop),
        .cfg_addr(cfg_addr), .cfg_addr10(cfg_addr10),
        .tx_empty(tx_empty), .tx_head(tx_head), .rx_full(rx_full),
        .be_done(be_done), .be_ack_in(be_ack_in),
        .be_valid(be_valid), .be_cmd(be_cmd), .be_wdata(be_wdata), .be_ack_out(be_ack_out),
        .tx_pop(tx_pop), .rx_push(rx_push), .xfer_end(xfer_end), .tx_phase(tx_phase),
        .st_done(st_done), .st_abort(st_abort), .st_noack(st_noack),
        .st_nodev(st_nodev), .st_mbusy(st_mbusy)
    );

    i2cseq_irq #(.CW(CW)) u_irq (
        .clk(clk), .rst_n(rst_n), .clr(sw_reset),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_phase(tx_phase), .trail_len(trail_len),
        .rx_push(rx_push), .rx_pop(rx_pop && !rx_empty), .xfer_end(xfer_end),
        .irq_clr(irq_clr), .irq_en(irq_en), .irq_stat(irq_stat), .irq(irq)
    );
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_reset,
    input logic       run,
    input logic       be_valid,
    input logic [1:0] be_cmd,
    input logic [7:0] be_wdata,
    input logic       be_done,
    input logic [3:0] irq_stat,
    input logic       st_done,
    input logic       st_abort,
    input logic       st_noack,
    input logic       st_nodev,
    input logic       st_mbusy
);
    assert_cmd_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && !be_done && !sw_reset |=> be_valid && $stable(be_cmd) && $stable(be_wdata));

    assert_valid_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> st_mbusy);

    assert_launch_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run && !st_mbusy && !sw_reset |=> st_mbusy);

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> !st_mbusy && (irq_stat == 4'h0));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> st_mbusy);

    assert_one_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_abort, st_noack, st_nodev}));

    assert_end_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mbusy && $past(st_mbusy) && !$past(sw_reset) |-> irq_stat[3]);
endmodule

bind i2c_auto_seq i2cseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .run(run),
    .be_valid(be_valid), .be_cmd(be_cmd), .be_wdata(be_wdata), .be_done(be_done),
    .irq_stat(irq_stat), .st_done(st_done), .st_abort(st_abort),
    .st_noack(st_noack), .st_nodev(st_nodev), .st_mbusy(st_mbusy)
);

// File: tb/i2c_auto_seq_tb.sv
module i2c_auto_seq_tb;
    localparam int CW  = 5;
    localparam int LAT = 3;
    localparam logic [1:0] C_ST = 2'd0, C_WR = 2'd1, C_RD = 2'd2, C_SP = 2'd3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, sw_reset = 1'b0, run = 1'b0;
    logic [7:0] cfg_len = '0;
    logic cfg_read = 1'b0, cfg_stop = 1'b0, cfg_addr10 = 1'b0;
    logic [9:0] cfg_addr = '0;
    logic [CW-1:0] tx_lvl = '0, rx_lvl = '0;
    logic [3:0] trail_len = 4'd2;
    logic tx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_full, rx_empty, irq, st_done, st_abort, st_noack, st_nodev, st_mbusy;
    logic [7:0] rx_data, be_wdata;
    logic [3:0] irq_en = '0, irq_clr = '0, irq_stat;
    logic be_valid, be_ack_out;
    logic [1:0] be_cmd;
    logic be_done = 1'b0, be_ack_in = 1'b1;
    logic [7:0] be_rdata = '0;

    i2c_auto_seq #(.LEN_W(8), .FIFO_DEPTH(16), .STALL_LIMIT(60), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .run(run),
        .cfg_len(cfg_len), .cfg_read(cfg_read), .cfg_stop(cfg_stop),
        .cfg_addr(cfg_addr), .cfg_addr10(cfg_addr10),
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .trail_len(trail_len),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_stat(irq_stat), .irq(irq),
        .st_done(st_done), .st_abort(st_abort), .st_noack(st_noack),
        .st_nodev(st_nodev), .st_mbusy(st_mbusy),
        .be_valid(be_valid), .be_cmd(be_cmd), .be_wdata(be_wdata), .be_ack_out(be_ack_out),
        .be_done(be_done), .be_ack_in(be_ack_in), .be_rdata(be_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    logic [10:0] exp_q[$];
    logic [7:0]  rx_exp[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic x(input logic [1:0] c, input logic a, input logic [7:0] d);
        exp_q.push_back({c, a, d});
    endtask

    // behavioural bit engine with expected-command comparison
    int eng_timer = 0, cmd_no = 0, cur_idx = 0, nack_idx = -1;
    int rd_seq = 0;
    bit eng_busy = 0;
    logic [1:0] cur_cmd = '0;
    always @(negedge clk) begin
        be_done = 1'b0;
        if (!rst_n || sw_reset) begin
            eng_busy = 0;
        end else if (eng_busy) begin
            eng_timer--;
            if (eng_timer == 0) begin
                eng_busy  = 0;
                be_done   = 1'b1;
                be_ack_in = (cur_idx == nack_idx) ? 1'b0 : 1'b1;
                if (cur_cmd == C_RD) begin
                    be_rdata = 8'h3C + 8'(rd_seq);
                    rd_seq++;
                    rx_exp.push_back(be_rdata);
                end
            end
        end else if (be_valid) begin
            logic [10:0] got, want;
            got = {be_cmd, be_ack_out, be_wdata};
            want = (exp_q.size() != 0) ? exp_q.pop_front() : 11'h7FF;
            chk("R12 R1 R2 R3 R4 command sequence", 32'(got), 32'(want));
            cur_cmd = be_cmd;
            cur_idx = cmd_no;
            cmd_no++;
            eng_busy = 1;
            eng_timer = LAT;
        end
    end

    task automatic push_tx(input logic [7:0] d);
        @(negedge clk); tx_push = 1'b1; tx_data = d;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic start_msg(input logic [7:0] len, input logic rd, input logic stp,
                             input logic [9:0] ad, input logic a10);
        @(negedge clk);
        cmd_no = 0;
        cfg_len = len; cfg_read = rd; cfg_stop = stp; cfg_addr = ad; cfg_addr10 = a10;
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!st_mbusy || st_done) break;
        end
    endtask

    task automatic pop_rx(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({req, " rx byte"}, 32'(rx_data), 32'((rx_exp.size() != 0) ? rx_exp.pop_front() : 8'hxx));
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 4'hF;
        @(negedge clk); irq_clr = 4'h0;
    endtask

    task automatic soft_reset();
        @(negedge clk); sw_reset = 1'b1;
        @(negedge clk); sw_reset = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset busy", 32'(st_mbusy), 0);
        chk("R5 reset status", 32'({st_done, st_abort, st_noack, st_nodev}), 0);
        chk("R9 reset irq", 32'(irq_stat), 0);
        chk("R12 reset valid", 32'(be_valid), 0);
        chk("R4 reset rx empty", 32'(rx_empty), 1);

        // 7-bit write of three bytes with stop
        tx_lvl = 5'd1;
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        x(C_ST,0,8'h00); x(C_WR,0,8'hA0); x(C_WR,0,8'h11); x(C_WR,0,8'h22); x(C_WR,0,8'h33); x(C_SP,0,8'h00);
        start_msg(8'd3, 1'b0, 1'b1, 10'h050, 1'b0);
        wait_end();
        chk("R3 write sequence complete", 32'(exp_q.size()), 0);
        chk("R5 status zero after stop", 32'({st_mbusy, st_done, st_abort, st_noack, st_nodev}), 0);
        chk("R9 completion bit", 32'(irq_stat[3]), 1);
        chk("R9 tx almost empty bit", 32'(irq_stat[0]), 1);
        irq_en = 4'b1000; @(negedge clk);
        chk("R9 irq enabled", 32'(irq), 1);
        irq_en = 4'b0000; @(negedge clk);
        chk("R9 irq masked", 32'(irq), 0);
        clear_irq();
        chk("R9 write-one clear", 32'(irq_stat), 0);

        // 7-bit read of four bytes with stop, trailing interrupt
        rx_lvl = 5'd15; trail_len = 4'd2;
        x(C_ST,0,8'h00); x(C_WR,0,8'hA1); x(C_RD,1,8'h00); x(C_RD,1,8'h00); x(C_RD,1,8'h00); x(C_RD,0,8'h00); x(C_SP,0,8'h00);
        start_msg(8'd4, 1'b1, 1'b1, 10'h050, 1'b0);
        wait_end();
        repeat (6) @(negedge clk);
        chk("R4 read sequence complete", 32'(exp_q.size()), 0);
        chk("R10 trailing set", 32'(irq_stat[2]), 1);
        chk("R9 rx almost full clear", 32'(irq_stat[1]), 0);
        pop_rx(4, "R4");
        chk("R4 rx drained", 32'(rx_empty), 1);
        clear_irq();

        // write without stop, then repeated-start read
        push_tx(8'hC7);
        x(C_ST,0,8'h00); x(C_WR,0,8'h84); x(C_WR,0,8'hC7);
        start_msg(8'd1, 1'b0, 1'b0, 10'h042, 1'b0);
        wait_end();
        repeat (4) @(negedge clk);
        chk("R5 hold no stop", 32'(exp_q.size()), 0);
        chk("R5 done and busy", 32'({st_done, st_mbusy}), 3);
        x(C_ST,0,8'h00); x(C_WR,0,8'h85); x(C_RD,0,8'h00); x(C_SP,0,8'h00);
        start_msg(8'd1, 1'b1, 1'b1, 10'h042, 1'b0);
        wait_end();
        chk("R5 repeated start read", 32'(exp_q.size()), 0);
        chk("R5 status zero", 32'({st_mbusy, st_done, st_abort, st_noack, st_nodev}), 0);
        pop_rx(1, "R5");
        clear_irq();

        // address NACK
        nack_idx = 1;
        x(C_ST,0,8'h00); x(C_WR,0,8'hEE); x(C_SP,0,8'h00);
        start_msg(8'd2, 1'b0, 1'b1, 10'h077, 1'b0);
        wait_end();
        chk("R6 nodev sequence", 32'(exp_q.size()), 0);
        chk("R6 nodev status", 32'({st_abort, st_noack, st_nodev, st_mbusy}), 32'b0010);

        // data NACK on the second byte
        nack_idx = 3;
        push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
        x(C_ST,0,8'h00); x(C_WR,0,8'hA0); x(C_WR,0,8'h01); x(C_WR,0,8'h02); x(C_SP,0,8'h00);
        start_msg(8'd3, 1'b0, 1'b1, 10'h050, 1'b0);
        wait_end();
        nack_idx = -1;
        chk("R3 noack sequence", 32'(exp_q.size()), 0);
        chk("R3 noack status", 32'({st_abort, st_noack, st_nodev, st_mbusy}), 32'b0100);

        // soft reset flushes the leftover byte 0x03 and the status
        soft_reset();
        chk("R11 status cleared", 32'({st_abort, st_noack, st_nodev, irq_stat}), 0);
        push_tx(8'h77);
        x(C_ST,0,8'h00); x(C_WR,0,8'hA0); x(C_WR,0,8'h77); x(C_SP,0,8'h00);
        start_msg(8'd1, 1'b0, 1'b1, 10'h050, 1'b0);
        wait_end();
        chk("R11 flushed byte not sent", 32'(exp_q.size()), 0);

        // length zero executes one byte
        push_tx(8'h5A);
        x(C_ST,0,8'h00); x(C_WR,0,8'hA0); x(C_WR,0,8'h5A); x(C_SP,0,8'h00);
        start_msg(8'd0, 1'b0, 1'b1, 10'h050, 1'b0);
        wait_end();
        chk("R7 zero length one byte", 32'(exp_q.size()), 0);

        // 10-bit write and read
        push_tx(8'h99);
        x(C_ST,0,8'h00); x(C_WR,0,8'hF4); x(C_WR,0,8'hC5); x(C_WR,0,8'h99); x(C_SP,0,8'h00);
        start_msg(8'd1, 1'b0, 1'b1, 10'h2C5, 1'b1);
        wait_end();
        chk("R2 ten-bit write", 32'(exp_q.size()), 0);
        x(C_ST,0,8'h00); x(C_WR,0,8'hF4); x(C_WR,0,8'hC5); x(C_ST,0,8'h00); x(C_WR,0,8'hF5);
        x(C_RD,1,8'h00); x(C_RD,0,8'h00); x(C_SP,0,8'h00);
        start_msg(8'd2, 1'b1, 1'b1, 10'h2C5, 1'b1);
        wait_end();
        chk("R2 ten-bit read", 32'(exp_q.size()), 0);
        pop_rx(2, "R2");
        clear_irq();

        // TX starvation abort
        x(C_ST,0,8'h00); x(C_WR,0,8'hA0); x(C_SP,0,8'h00);
        start_msg(8'd1, 1'b0, 1'b1, 10'h050, 1'b0);
        wait_end();
        chk("R8 starvation sequence", 32'(exp_q.size()), 0);
        chk("R8 abort status", 32'({st_abort, st_noack, st_nodev, st_mbusy}), 32'b1000);

        // RX almost full, trailing must stay clear
        rx_lvl = 5'd1; clear_irq();
        x(C_ST,0,8'h00); x(C_WR,0,8'hA1); x(C_RD,0,8'h00); x(C_SP,0,8'h00);
        start_msg(8'd1, 1'b1, 1'b1, 10'h050, 1'b0);
        wait_end();
        repeat (20) @(negedge clk);
        chk("R9 rx almost full set", 32'(irq_stat[1]), 1);
        chk("R10 trailing clear at level", 32'(irq_stat[2]), 0);
        pop_rx(1, "R9");
        clear_irq();

        // soft reset in the middle of a stalled write
        x(C_ST,0,8'h00); x(C_WR,0,8'hA0);
        start_msg(8'd2, 1'b0, 1'b1, 10'h050, 1'b0);
        repeat (20) @(negedge clk);
        chk("R11 busy before reset", 32'(st_mbusy), 1);
        soft_reset();
        chk("R11 idle after reset", 32'({st_mbusy, irq_stat}), 0);
        chk("R11 no pending commands", 32'(exp_q.size()), 0);
        repeat (10) @(negedge clk);
        chk("R12 no command after reset", 32'(be_valid), 0);

        summary();
        $finish;
    end
endmodule